// File: doc/BRIEF.md
# Ring-Connected Engine Data Rotator

This block links a configurable number of processing nodes in a closed loop and moves image sets around that loop so that each node meets every image set of a group once. A host first fills an image store and, for each node, a coefficient store. It then pulses a start input. The controller walks the image sets group by group. For each group it copies one set into each node, with node e taking the e-th set of the group. It then performs one rotation step per node count. On each step every node hands its set downstream and takes its upstream neighbour's set, so node e receives data from node e-1 and node 0 receives from the last node.

Each node keeps its coefficients in a cyclic layout. The host writes a coefficient by naming the node and the logical image set index. The node stores the value at the physical slot equal to the rotation step at which that set will reach it. The controller can therefore issue one plain sequential read address, group base plus step, to all nodes at once. Each node multiplies the set it holds by the coefficient read at that address and adds the product to its accumulator. At the end of a run, each accumulator holds the dot product of all image sets with that node's coefficients. The accumulators and the current ring contents are visible on flat output buses.

Top module: `ring_rot_top`

## Requirements
- R1: After synchronous reset, busy and done are 0, step_idx is 0, every ring_data slice is 0 and every acc_data slice is 0.
- R2: A start pulse while idle clears all accumulators. One cycle later group 0 is loaded, so node e holds image set e and step_idx reads 0.
- R3: On each rotation step the slice of node e takes the previous value of node e-1, and node 0 takes the previous value of node NE-1. After s steps of a group, node e therefore holds set (e - s) mod NE of that group, and step_idx reads s.
- R4: At the end of a run, acc_data slice e equals the sum over all image sets n < NIM of image[n] * coef(e, n). Here coef(e, n) is the value the host wrote with coef_node = e and coef_set = n. Sums are unsigned.
- R5: The run processes ceil(NIM/NE) groups. A ring position whose set index is NIM or more is loaded with 0, so coefficients written for those indices (up to ceil(NIM/NE)*NE - 1) add nothing.
- R6: After NE steps the ring is back in load order. When the run ends, node e holds image[(G-1)*NE + e] for the last group G-1, or 0 if that index is NIM or more.
- R7: busy is 1 from the cycle after the accepted start until done. done is a single-cycle pulse, and busy is 0 in the cycle after it. While idle, ring_data and acc_data hold their values.
- R8: While busy, image writes, coefficient writes and start are ignored. Rerunning without new writes gives the results the earlier contents predict.
- R9: done is first seen high ceil(NIM/NE)*(NE+1)+1 rising edges after the edge that samples start, counting that edge. This is 52 edges with NE=16 and NIM=40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; taken only while idle |
| img_we | input | 1 | Image store write enable (idle only) |
| img_addr | input | SET_W | Image set index, writes at NIM or above are dropped |
| img_wdata | input | DATA_W | Image set value |
| coef_we | input | 1 | Coefficient write enable (idle only) |
| coef_node | input | NODE_W | Target node of the coefficient write |
| coef_set | input | SET_W | Logical image set index the coefficient pairs with |
| coef_wdata | input | COEF_W | Coefficient value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| step_idx | output | NODE_W | Rotation step within the current group |
| ring_data | output | NE*DATA_W | Set held by each node, node e at bits e*DATA_W upward |
| acc_data | output | NE*ACC_W | Accumulator of each node, node e at bits e*ACC_W upward |

## Verification
The hardest situation to reach from the ports is a host write or a second start that lands in the middle of a rotation. In that case the ring, the accumulators and the stores must all behave as if the write never happened. The bench injects an image write, a coefficient write and a start pulse at a fixed edge inside the first group. It then checks that run's sums and the sums of a second run made without new writes. The zero-filled tail of the last group is reached by writing nonzero coefficients into every padding slot, so that any leak of a nonzero value into a padded position changes the sums. The bench also counts edges from start to sample the ring at exact steps.

// File: rtl/ring_rot_pkg.sv
package ring_rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ROT,
        ST_DONE
    } rot_state_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic shift;
        logic done;
    } ring_ctl_t;

    // width of an index covering n values, never below 1
    function automatic int w_min1(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // rotation step at which set j of a group reaches node e
    function automatic int cyc_slot(input int node, input int set_in_grp, input int ne);
        return (node - set_in_grp + ne) % ne;
    endfunction

endpackage

// File: rtl/ring_rot_ctrl.sv
module ring_rot_ctrl
    import ring_rot_pkg::*;
#(
    parameter int NE     = 16,
    parameter int NGRP   = 3,
    parameter int NODE_W = 4,
    parameter int GRP_W  = 2,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output ring_ctl_t         ctl,
    output logic [GRP_W-1:0]  grp,
    output logic [NODE_W-1:0] step,
    output logic [SLOT_W-1:0] rd_addr,
    output logic              busy
);

    rot_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            grp   <= '0;
            step  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LOAD;
                        grp   <= '0;
                        step  <= '0;
                    end
                end
                ST_LOAD: state <= ST_ROT;
                ST_ROT: begin
                    if (step == NODE_W'(NE - 1)) begin
                        step <= '0;
                        if (grp == GRP_W'(NGRP - 1)) begin
                            state <= ST_DONE;
                        end else begin
                            grp   <= grp + 1'b1;
                            state <= ST_LOAD;
                        end
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.clear = (state == ST_IDLE) && start;
        ctl.load  = (state == ST_LOAD);
        ctl.shift = (state == ST_ROT);
        ctl.done  = (state == ST_DONE);
        busy      = (state != ST_IDLE);
        rd_addr   = SLOT_W'(int'(grp) * NE + int'(step));
    end

endmodule

// File: rtl/ring_rot_node.sv
module ring_rot_node
    import ring_rot_pkg::*;
#(
    parameter int NODE_ID = 0,
    parameter int NE      = 16,
    parameter int SLOTS   = 48,
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8,
    parameter int ACC_W   = 32,
    parameter int SLOT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ring_ctl_t         ctl,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] up_data,
    input  logic              cw_en,
    input  logic [SLOT_W-1:0] cw_set,
    input  logic [COEF_W-1:0] cw_data,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [DATA_W-1:0] ring_q,
    output logic [ACC_W-1:0]  acc_q
);

    logic [COEF_W-1:0] coef_mem [SLOTS];
    logic [SLOT_W-1:0] cw_phys;
    logic [ACC_W-1:0]  prod;

    // logical set index -> cyclic physical slot for this node position
    always_comb begin
        cw_phys = SLOT_W'((int'(cw_set) / NE) * NE
                          + cyc_slot(NODE_ID, int'(cw_set) % NE, NE));
        prod    = ACC_W'(ring_q) * ACC_W'(coef_mem[rd_addr]);
    end

    always_ff @(posedge clk) begin
        if (cw_en) begin
            coef_mem[cw_phys] <= cw_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
            acc_q  <= '0;
        end else begin
            if (ctl.clear) begin
                acc_q <= '0;
            end
            if (ctl.load) begin
                ring_q <= load_data;
            end else if (ctl.shift) begin
                ring_q <= up_data;
                acc_q  <= acc_q + prod;
            end
        end
    end

endmodule

// File: rtl/ring_rot_top.sv
module ring_rot_top
    import ring_rot_pkg::*;
#(
    parameter int NE     = 16,
    parameter int NIM    = 40,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 32,
    localparam int NGRP   = (NIM + NE - 1) / NE,
    localparam int SLOTS  = NGRP * NE,
    localparam int NODE_W = w_min1(NE),
    localparam int GRP_W  = w_min1(NGRP),
    localparam int SET_W  = w_min1(SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   img_we,
    input  logic [SET_W-1:0]       img_addr,
    input  logic [DATA_W-1:0]      img_wdata,
    input  logic                   coef_we,
    input  logic [NODE_W-1:0]      coef_node,
    input  logic [SET_W-1:0]       coef_set,
    input  logic [COEF_W-1:0]      coef_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [NODE_W-1:0]      step_idx,
    output logic [NE*DATA_W-1:0]   ring_data,
    output logic [NE*ACC_W-1:0]    acc_data
);

    ring_ctl_t         ctl;
    logic [GRP_W-1:0]  grp;
    logic [SET_W-1:0]  rd_addr;
    logic [DATA_W-1:0] img_mem [NIM];
    logic [DATA_W-1:0] ring_q [NE];

    ring_rot_ctrl #(
        .NE(NE), .NGRP(NGRP), .NODE_W(NODE_W), .GRP_W(GRP_W), .SLOT_W(SET_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .ctl(ctl),
        .grp(grp), .step(step_idx), .rd_addr(rd_addr), .busy(busy)
    );

    assign done = ctl.done;

    always_ff @(posedge clk) begin
        if (img_we && !busy && (int'(img_addr) < NIM)) begin
            img_mem[img_addr] <= img_wdata;
        end
    end

    for (genvar e = 0; e < NE; e++) begin : g_node
        logic [DATA_W-1:0] load_val;
        logic              cw_en;
        int                src;

        always_comb begin
            src      = int'(grp) * NE + e;
            load_val = (src < NIM) ? img_mem[src] : '0;
            cw_en    = coef_we && !busy && (coef_node == NODE_W'(e))
                       && (int'(coef_set) < SLOTS);
        end

        ring_rot_node #(
            .NODE_ID(e), .NE(NE), .SLOTS(SLOTS), .DATA_W(DATA_W),
            .COEF_W(COEF_W), .ACC_W(ACC_W), .SLOT_W(SET_W)
        ) u_node (
            .clk(clk), .rst(rst), .ctl(ctl),
            .load_data(load_val),
            .up_data(ring_q[(e + NE - 1) % NE]),
            .cw_en(cw_en), .cw_set(coef_set), .cw_data(coef_wdata),
            .rd_addr(rd_addr),
            .ring_q(ring_q[e]),
            .acc_q(acc_data[e*ACC_W +: ACC_W])
        );

        assign ring_data[e*DATA_W +: DATA_W] = ring_q[e];
    end

endmodule

// File: rtl/ring_rot_chk.sv
module ring_rot_chk #(
    parameter int NE     = 16,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 32,
    parameter int NODE_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 load,
    input logic                 shift,
    input logic [NODE_W-1:0]    step_idx,
    input logic [NE*DATA_W-1:0] ring_data,
    input logic [NE*ACC_W-1:0]  acc_data
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(ring_data) && $stable(acc_data)));

    // R2
    load_step_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (step_idx == '0));

    // R3
    ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> (ring_data[DATA_W-1:0] == $past(ring_data[NE*DATA_W-1 -: DATA_W])));

    // R3
    ring_next_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> (ring_data[2*DATA_W-1 -: DATA_W] == $past(ring_data[DATA_W-1:0])));

endmodule

bind ring_rot_top ring_rot_chk #(
    .NE(NE), .DATA_W(DATA_W), .ACC_W(ACC_W), .NODE_W(NODE_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .load(ctl.load), .shift(ctl.shift), .step_idx(step_idx),
    .ring_data(ring_data), .acc_data(acc_data)
);

// File: tb/ring_rot_top_tb.sv
module ring_rot_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE     = 16;
    localparam int NIM    = 40;
    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int ACC_W  = 32;
    localparam int NGRP   = (NIM + NE - 1) / NE;
    localparam int SLOTS  = NGRP * NE;
    localparam int NODE_W = 4;
    localparam int SET_W  = 6;
    localparam int LAT    = NGRP * (NE + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic img_we = 1'b0;
    logic [SET_W-1:0] img_addr = '0;
    logic [DATA_W-1:0] img_wdata = '0;
    logic coef_we = 1'b0;
    logic [NODE_W-1:0] coef_node = '0;
    logic [SET_W-1:0] coef_set = '0;
    logic [COEF_W-1:0] coef_wdata = '0;
    logic busy, done;
    logic [NODE_W-1:0] step_idx;
    logic [NE*DATA_W-1:0] ring_data;
    logic [NE*ACC_W-1:0] acc_data;

    int checks = 0;
    int errors = 0;
    int img_m [NIM];
    int coef_m [NE][SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_rot_top #(
        .NE(NE), .NIM(NIM), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
        .coef_we(coef_we), .coef_node(coef_node), .coef_set(coef_set),
        .coef_wdata(coef_wdata),
        .busy(busy), .done(done), .step_idx(step_idx),
        .ring_data(ring_data), .acc_data(acc_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ring_at(input int e);
        return longint'(ring_data[e*DATA_W +: DATA_W]);
    endfunction

    function automatic longint exp_set(input int g, input int j);
        int n = g * NE + j;
        return (n < NIM) ? longint'(img_m[n]) : 0;
    endfunction

    task automatic load_all(input int seed, input bit max_val);
        for (int n = 0; n < NIM; n++) begin
            @(negedge clk);
            img_m[n]  = max_val ? 255 : ((n * 37 + seed * 11 + 5) & 8'hFF);
            img_we    = 1'b1;
            img_addr  = SET_W'(n);
            img_wdata = DATA_W'(img_m[n]);
        end
        @(negedge clk);
        img_we = 1'b0;
        for (int e = 0; e < NE; e++) begin
            for (int n = 0; n < SLOTS; n++) begin
                @(negedge clk);
                coef_m[e][n] = max_val ? 255 : ((e * 29 + n * 13 + seed * 3 + 1) & 8'hFF);
                coef_we    = 1'b1;
                coef_node  = NODE_W'(e);
                coef_set   = SET_W'(n);
                coef_wdata = COEF_W'(coef_m[e][n]);
            end
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // runs one pass; optionally injects writes and start mid-run
    task automatic do_run(input string tag, input bit inject);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        cnt = 1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R7 busy after start"}, busy, 1);
        while (!done && cnt < 500) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 2) begin
                check({tag, " R2 step after load"}, step_idx, 0);
                for (int e = 0; e < NE; e++)
                    check({tag, " R2 group0 load"}, ring_at(e), exp_set(0, e));
            end
            if (cnt == 7) begin
                check({tag, " R3 step index"}, step_idx, 5);
                for (int e = 0; e < NE; e++)
                    check({tag, " R3 rotated ring"}, ring_at(e), exp_set(0, (e - 5 + NE) % NE));
            end
            if (inject && cnt == 10) begin
                img_we = 1'b1; img_addr = 6'd3; img_wdata = 8'hAA;
                coef_we = 1'b1; coef_node = 4'd2; coef_set = 6'd3; coef_wdata = 8'h55;
                start = 1'b1;
            end
            if (inject && cnt == 11) begin
                img_we = 1'b0; coef_we = 1'b0; start = 1'b0;
            end
        end
        check({tag, " R9 latency"}, cnt, LAT);
        for (int e = 0; e < NE; e++) begin
            longint s = 0;
            for (int n = 0; n < NIM; n++) s += longint'(img_m[n]) * coef_m[e][n];
            check({tag, " R4 R5 accumulated sum"}, longint'(acc_data[e*ACC_W +: ACC_W]), s);
            check({tag, " R6 R5 final ring"}, ring_at(e), exp_set(NGRP - 1, e));
        end
        @(negedge clk);
        check({tag, " R7 idle after done"}, busy, 0);
        check({tag, " R7 done pulse"}, done, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 step", step_idx, 0);
        check("R1 ring", (ring_data == '0) ? 1 : 0, 1);
        check("R1 acc", (acc_data == '0) ? 1 : 0, 1);
    endtask

    task automatic t_basic();
        load_all(1, 1'b0);
        do_run("basic", 1'b0);
    endtask

    task automatic t_ignore_busy();
        load_all(2, 1'b0);
        do_run("R8 inject", 1'b1);
        do_run("R8 rerun", 1'b0);
    endtask

    task automatic t_max();
        load_all(0, 1'b1);
        do_run("max", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_ignore_busy();
        t_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule